// File: doc/BRIEF.md
# String Operation Sequencer

The sequencer carries out one byte or word string primitive (copy, load, store, compare, scan) on a memory reached through a single synchronous byte-wide port. The primitive can run once or be repeated under a count. A repeated compare or scan can also stop early, depending on whether the last two values matched. On a start pulse the block latches the source and destination pointers, the count, the accumulator, the direction, the width and two segment bases. It then walks through the iterations and raises done when the run is complete.

Each iteration begins with a check cycle that tests the count. The byte accesses follow, one per cycle, with read data arriving one cycle after its request. A completion cycle then steps the pointers, decrements the count and updates the flags. Word operands are moved as two byte accesses, low byte first. The final pointers, count, accumulator and the zero and borrow flags stay on the outputs until the next start.

Top module: `strop_seq`

## Requirements
- R1: After reset, done, busy, memRead and memWrite are 0. The pointers, count, accumulator, zeroFlag and borrowFlag all read 0.
- R2: Every memory address is (segment × 16 + offset) modulo 2^20. A word is moved as two byte accesses: the low byte at the offset first, then the high byte at offset+1, where the offset wraps within 16 bits.
- R3: opCode 0 (copy) reads srcSeg:srcPtr, writes the same bytes to dstSeg:dstPtr, and steps both pointers.
- R4: opCode 1 (load) reads srcSeg:srcPtr into the accumulator and steps only srcPtr. A byte load replaces the low 8 bits and keeps the high 8 bits.
- R5: opCode 2 (store) writes the accumulator (low byte, or the full word) to dstSeg:dstPtr and steps only dstPtr.
- R6: opCode 3 (compare) forms source minus destination at the operand width. zeroFlag=1 when they are equal and borrowFlag=1 when source < destination (unsigned). Both pointers step.
- R7: opCode 4 (scan) forms accumulator minus dstSeg:dstPtr at the operand width, sets zeroFlag and borrowFlag as in R6, and steps only dstPtr.
- R8: With dirDown=0 the pointers advance and with dirDown=1 they retreat. The step is 1 for byte width (wide=0) and 2 for word width (wide=1).
- R9: With a nonzero prefix, a count of 0 found at an iteration's check ends the run with no memory access and no change to pointers, count or accumulator.
- R10: prefix 1 repeats until the count reaches 0. With opCode 0, 1 or 2, prefixes 2 and 3 behave exactly like prefix 1.
- R11: prefix 2 ends the run after a compare or scan that leaves zeroFlag=0. Prefix 3 ends it after one that leaves zeroFlag=1. Either way the count has been decremented once per executed iteration.
- R12: prefix 0 executes exactly one primitive and leaves the count unchanged.
- R13: A run takes one check cycle per count test, one cycle per byte access and one completion cycle per iteration. Done is high for exactly one cycle, in the cycle after the last of these. The outputs then show the final values. The flags keep their previous values when no compare or scan ran.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| opCode | input | 3 | Primitive: 0 copy, 1 load, 2 store, 3 compare, 4 scan |
| prefix | input | 2 | 0 single, 1 repeat, 2 repeat while equal, 3 repeat while unequal |
| wide | input | 1 | 0 byte, 1 word |
| dirDown | input | 1 | Pointer direction, 1 = decrement |
| srcPtrIn | input | 16 | Initial source offset |
| dstPtrIn | input | 16 | Initial destination offset |
| countIn | input | 16 | Initial repeat count |
| accIn | input | 16 | Initial accumulator |
| srcSegIn | input | 16 | Source segment base |
| dstSegIn | input | 16 | Destination segment base |
| memRdata | input | 8 | Read data, valid one cycle after memRead |
| memRead | output | 1 | Read request |
| memWrite | output | 1 | Write request |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| srcPtrOut | output | 16 | Current source offset |
| dstPtrOut | output | 16 | Current destination offset |
| countOut | output | 16 | Current count |
| accOut | output | 16 | Current accumulator |
| zeroFlag | output | 1 | Equality result of the last compare or scan |
| borrowFlag | output | 1 | Unsigned borrow of the last compare or scan |

## Verification
The embedded properties assume three things about the inputs. The memory returns the requested byte in exactly the cycle after each read. Start is only raised while busy is low. opCode stays within 0 to 4. The stimulus meets all three: a responder in the bench answers every read on the following clock, start is pulsed once per run after the previous done, and only the five defined operation codes are applied. Under these conditions the count can only stay or fall by one, and each pointer can only stay or move by one or two per cycle. These are the relations the datapath properties rely on.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 16;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_COPY = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2, OP_CMP = 3'd3, OP_SCAN = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PF_SINGLE = 2'd0, PF_REPEAT = 2'd1, PF_WHILE_EQ = 2'd2, PF_WHILE_NE = 2'd3
  } pfx_e;

  // slot[1] selects destination side, slot[0] selects the high byte
  typedef enum logic [1:0] {
    SL_SRC_LO = 2'd0, SL_SRC_HI = 2'd1, SL_DST_LO = 2'd2, SL_DST_HI = 2'd3
  } slot_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SRC0, ST_SRC1, ST_DST0, ST_DST1, ST_FIN, ST_DONE
  } state_e;

  typedef struct packed {
    logic  load;
    logic  rdEn;
    logic  wrEn;
    slot_e slot;
    logic  wrAcc;
    logic  fin;
    logic  decCount;
    logic  updFlags;
    logic  cmpAcc;
    logic  updAcc;
    logic  stepSrc;
    logic  stepDst;
  } strobe_t;
endpackage

// File: rtl/strop_ctrl.sv
module strop_ctrl
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opIn,
  input  logic [1:0] pfxIn,
  input  logic       wideIn,
  input  logic       countZero,
  input  logic       cmpZero,
  output strobe_t    stb,
  output logic       done,
  output logic       busy
);
  state_e state, nextState;
  op_e    op;
  pfx_e   pfx;
  logic   wide;

  logic opValid, usesSrc, usesDst, dstWrite, isCmp, stopEarly;

  always_comb begin
    opValid  = (op <= OP_SCAN);
    usesSrc  = (op == OP_COPY) || (op == OP_LOAD) || (op == OP_CMP);
    usesDst  = (op != OP_LOAD);
    dstWrite = (op == OP_COPY) || (op == OP_STORE);
    isCmp    = (op == OP_CMP) || (op == OP_SCAN);
    stopEarly = isCmp && (((pfx == PF_WHILE_EQ) && !cmpZero) ||
                          ((pfx == PF_WHILE_NE) &&  cmpZero));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      op    <= OP_COPY;
      pfx   <= PF_SINGLE;
      wide  <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.load) begin
        op   <= op_e'(opIn);
        pfx  <= pfx_e'(pfxIn);
        wide <= wideIn;
      end
    end
  end

  always_comb begin
    stb       = '0;
    done      = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.load  = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (!opValid || ((pfx != PF_SINGLE) && countZero)) nextState = ST_DONE;
        else nextState = usesSrc ? ST_SRC0 : ST_DST0;
      end
      ST_SRC0: begin
        stb.rdEn  = 1'b1;
        stb.slot  = SL_SRC_LO;
        nextState = wide ? ST_SRC1 : (usesDst ? ST_DST0 : ST_FIN);
      end
      ST_SRC1: begin
        stb.rdEn  = 1'b1;
        stb.slot  = SL_SRC_HI;
        nextState = usesDst ? ST_DST0 : ST_FIN;
      end
      ST_DST0, ST_DST1: begin
        stb.rdEn  = !dstWrite;
        stb.wrEn  = dstWrite;
        stb.wrAcc = (op == OP_STORE);
        stb.slot  = (state == ST_DST0) ? SL_DST_LO : SL_DST_HI;
        nextState = (state == ST_DST0 && wide) ? ST_DST1 : ST_FIN;
      end
      ST_FIN: begin
        stb.fin      = 1'b1;
        stb.decCount = (pfx != PF_SINGLE);
        stb.updFlags = isCmp;
        stb.cmpAcc   = (op == OP_SCAN);
        stb.updAcc   = (op == OP_LOAD);
        stb.stepSrc  = usesSrc;
        stb.stepDst  = usesDst;
        if (pfx == PF_SINGLE || stopEarly) nextState = ST_DONE;
        else nextState = ST_CHECK;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !(stb.rdEn || stb.wrEn));

  assert_zero_count_no_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && pfx != PF_SINGLE && countZero) |=> (done && !stb.rdEn && !stb.wrEn));

  assert_early_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN && pfx == PF_WHILE_EQ && isCmp && !cmpZero) |=> done);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/strop_dp.sv
module strop_dp
  import strop_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              dirIn,
  input  logic              wideIn,
  input  logic [OFF_W-1:0]  srcPtrIn,
  input  logic [OFF_W-1:0]  dstPtrIn,
  input  logic [OFF_W-1:0]  countIn,
  input  logic [WORD_W-1:0] accIn,
  input  logic [OFF_W-1:0]  srcSegIn,
  input  logic [OFF_W-1:0]  dstSegIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              memRead,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [OFF_W-1:0]  srcPtr,
  output logic [OFF_W-1:0]  dstPtr,
  output logic [OFF_W-1:0]  count,
  output logic [WORD_W-1:0] acc,
  output logic              zeroFlag,
  output logic              borrowFlag,
  output logic              countZero,
  output logic              cmpZero
);
  localparam int NSLOT = 4;

  logic [OFF_W-1:0] srcSeg, dstSeg;
  logic             dirDown, wide;
  logic             pendValid;
  logic [1:0]       pendSlot;
  logic [BYTE_W-1:0] byteNow [NSLOT];

  // captured bytes with a bypass for the byte arriving this cycle
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    logic [BYTE_W-1:0] held;
    logic              hit;
    assign hit = pendValid && (pendSlot == 2'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    held <= '0;
      else if (hit) held <= memRdata;
    end
    assign byteNow[g] = hit ? memRdata : held;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSlot  <= '0;
    end else begin
      pendValid <= stb.rdEn;
      pendSlot  <= stb.slot;
    end
  end

  // address formation
  logic              sideDst, hiByte;
  logic [OFF_W-1:0]  segSel, offSel;
  always_comb begin
    sideDst  = stb.slot[1];
    hiByte   = stb.slot[0];
    segSel   = sideDst ? dstSeg : srcSeg;
    offSel   = (sideDst ? dstPtr : srcPtr) + OFF_W'(hiByte);
    memAddr  = (ADDR_W'(segSel) << SEG_SHIFT) + ADDR_W'(offSel);
    memRead  = stb.rdEn;
    memWrite = stb.wrEn;
    if (stb.wrAcc) memWdata = hiByte ? acc[WORD_W-1:BYTE_W] : acc[BYTE_W-1:0];
    else           memWdata = hiByte ? byteNow[SL_SRC_HI] : byteNow[SL_SRC_LO];
  end

  // compare unit
  logic [WORD_W-1:0] srcWord, dstWord, aOp;
  logic [WORD_W:0]   diffW;
  logic [BYTE_W:0]   diffB;
  logic              cmpBorrow;
  always_comb begin
    srcWord   = {byteNow[SL_SRC_HI], byteNow[SL_SRC_LO]};
    dstWord   = {byteNow[SL_DST_HI], byteNow[SL_DST_LO]};
    aOp       = stb.cmpAcc ? acc : srcWord;
    diffW     = {1'b0, aOp} - {1'b0, dstWord};
    diffB     = {1'b0, aOp[BYTE_W-1:0]} - {1'b0, dstWord[BYTE_W-1:0]};
    cmpZero   = wide ? (diffW[WORD_W-1:0] == '0) : (diffB[BYTE_W-1:0] == '0);
    cmpBorrow = wide ? diffW[WORD_W] : diffB[BYTE_W];
  end

  logic [OFF_W-1:0] stepAmt, delta;
  always_comb begin
    stepAmt = wide ? OFF_W'(2) : OFF_W'(1);
    delta   = dirDown ? (~stepAmt + OFF_W'(1)) : stepAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr <= '0; dstPtr <= '0; count <= '0; acc <= '0;
      srcSeg <= '0; dstSeg <= '0; dirDown <= 1'b0; wide <= 1'b0;
      zeroFlag <= 1'b0; borrowFlag <= 1'b0;
    end else if (stb.load) begin
      srcPtr <= srcPtrIn; dstPtr <= dstPtrIn; count <= countIn; acc <= accIn;
      srcSeg <= srcSegIn; dstSeg <= dstSegIn; dirDown <= dirIn; wide <= wideIn;
    end else if (stb.fin) begin
      if (stb.stepSrc)  srcPtr <= srcPtr + delta;
      if (stb.stepDst)  dstPtr <= dstPtr + delta;
      if (stb.decCount) count  <= count - OFF_W'(1);
      if (stb.updFlags) begin
        zeroFlag   <= cmpZero;
        borrowFlag <= cmpBorrow;
      end
      if (stb.updAcc) acc <= wide ? srcWord : {acc[WORD_W-1:BYTE_W], byteNow[SL_SRC_LO]};
    end
  end

  assign countZero = (count == '0);

  function automatic logic stepOk(input logic [OFF_W-1:0] nv, input logic [OFF_W-1:0] ov);
    logic [OFF_W-1:0] d;
    d = nv - ov;
    return (d == OFF_W'(0)) || (d == OFF_W'(1)) || (d == OFF_W'(2)) ||
           (d == ~OFF_W'(0)) || (d == ~OFF_W'(1));
  endfunction

  assert_count_only_falls_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> (count == $past(count) || count == $past(count) - OFF_W'(1)));

  assert_src_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> stepOk(srcPtr, $past(srcPtr)));

  assert_dst_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> stepOk(dstPtr, $past(dstPtr)));

  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic [1:0]        prefix,
  input  logic              wide,
  input  logic              dirDown,
  input  logic [OFF_W-1:0]  srcPtrIn,
  input  logic [OFF_W-1:0]  dstPtrIn,
  input  logic [OFF_W-1:0]  countIn,
  input  logic [WORD_W-1:0] accIn,
  input  logic [OFF_W-1:0]  srcSegIn,
  input  logic [OFF_W-1:0]  dstSegIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              memRead,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  srcPtrOut,
  output logic [OFF_W-1:0]  dstPtrOut,
  output logic [OFF_W-1:0]  countOut,
  output logic [WORD_W-1:0] accOut,
  output logic              zeroFlag,
  output logic              borrowFlag
);
  strobe_t stb;
  logic    countZero, cmpZero;

  strop_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opCode), .pfxIn(prefix),
    .wideIn(wide), .countZero(countZero), .cmpZero(cmpZero),
    .stb(stb), .done(done), .busy(busy)
  );

  strop_dp #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .dirIn(dirDown), .wideIn(wide),
    .srcPtrIn(srcPtrIn), .dstPtrIn(dstPtrIn), .countIn(countIn), .accIn(accIn),
    .srcSegIn(srcSegIn), .dstSegIn(dstSegIn), .memRdata(memRdata),
    .memRead(memRead), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .srcPtr(srcPtrOut), .dstPtr(dstPtrOut), .count(countOut), .acc(accOut),
    .zeroFlag(zeroFlag), .borrowFlag(borrowFlag),
    .countZero(countZero), .cmpZero(cmpZero)
  );
endmodule

// File: tb/sim_strop_seq.sv
module sim_strop_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [2:0] opCode = '0;
  logic [1:0] prefix = '0;
  logic wide = 1'b0, dirDown = 1'b0;
  logic [15:0] srcPtrIn = '0, dstPtrIn = '0, countIn = '0, accIn = '0, srcSegIn = '0, dstSegIn = '0;
  logic [7:0] memRdata = '0;
  logic memRead, memWrite, busy, done, zeroFlag, borrowFlag;
  logic [19:0] memAddr;
  logic [7:0] memWdata;
  logic [15:0] srcPtrOut, dstPtrOut, countOut, accOut;

  strop_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [int];
  logic [7:0] refMem [int];
  bit         expWe [$];
  logic [19:0] expAddr [$];
  logic [7:0] expData [$];
  string      expTag [$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;
  bit modelZf = 0, modelCf = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder: data back one cycle after the request
  always @(posedge clk) begin
    if (memWrite) mem[int'(memAddr)] = memWdata;
    memRdata <= (memRead && mem.exists(int'(memAddr))) ? mem[int'(memAddr)] : 8'h00;
  end

  // per-cycle comparison of port traffic against the model's queue
  always @(negedge clk) begin
    if (rstN && (memRead || memWrite)) begin
      if (expAddr.size() == 0) begin
        check(1'b0, "R2", "unexpected access", {12'h0, memAddr}, 32'h0);
      end else begin
        bit we; logic [19:0] a; logic [7:0] d; string t;
        we = expWe.pop_front(); a = expAddr.pop_front();
        d = expData.pop_front(); t = expTag.pop_front();
        check(memWrite == we, t, "access kind", {31'h0, memWrite}, {31'h0, we});
        check(memAddr == a, "R2", "address", {12'h0, memAddr}, {12'h0, a});
        if (we) check(memWdata == d, t, "write data", {24'h0, memWdata}, {24'h0, d});
      end
    end
  end

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return 20'({seg, 4'h0}) + 20'(off);
  endfunction

  function automatic logic [7:0] refRd(input logic [19:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  task automatic push(input bit we, input logic [19:0] a, input logic [7:0] d, input string t);
    expWe.push_back(we); expAddr.push_back(a); expData.push_back(d); expTag.push_back(t);
  endtask

  task automatic model(input int op, input int pfx, input bit w, input bit d,
                       input logic [15:0] sp0, input logic [15:0] dp0, input logic [15:0] cnt0,
                       input logic [15:0] acc0, input logic [15:0] ss, input logic [15:0] ds,
                       input string tag,
                       output logic [15:0] sp, output logic [15:0] dp, output logic [15:0] cnt,
                       output logic [15:0] ac, output int ncyc);
    int nChk = 0, nAcc = 0, nFin = 0;
    logic [15:0] src, dst, a, step;
    bit usesSrc, usesDst, isCmp;
    sp = sp0; dp = dp0; cnt = cnt0; ac = acc0;
    usesSrc = (op == 0 || op == 1 || op == 3);
    usesDst = (op != 1);
    isCmp   = (op == 3 || op == 4);
    step    = w ? 16'd2 : 16'd1;
    forever begin
      nChk++;
      if (op > 4) break;
      if (pfx != 0 && cnt == 0) break;
      src = '0; dst = '0;
      if (usesSrc) begin
        src[7:0] = refRd(phys(ss, sp)); push(1'b0, phys(ss, sp), 8'h0, tag); nAcc++;
        if (w) begin
          src[15:8] = refRd(phys(ss, sp + 16'd1)); push(1'b0, phys(ss, sp + 16'd1), 8'h0, tag); nAcc++;
        end
      end
      if (usesDst) begin
        if (op == 0 || op == 2) begin
          logic [15:0] wv;
          wv = (op == 0) ? src : ac;
          refMem[int'(phys(ds, dp))] = wv[7:0]; push(1'b1, phys(ds, dp), wv[7:0], tag); nAcc++;
          if (w) begin
            refMem[int'(phys(ds, dp + 16'd1))] = wv[15:8];
            push(1'b1, phys(ds, dp + 16'd1), wv[15:8], tag); nAcc++;
          end
        end else begin
          dst[7:0] = refRd(phys(ds, dp)); push(1'b0, phys(ds, dp), 8'h0, tag); nAcc++;
          if (w) begin
            dst[15:8] = refRd(phys(ds, dp + 16'd1)); push(1'b0, phys(ds, dp + 16'd1), 8'h0, tag); nAcc++;
          end
        end
      end
      nFin++;
      if (isCmp) begin
        a = (op == 4) ? ac : src;
        if (w) begin modelZf = (a == dst); modelCf = (a < dst); end
        else   begin modelZf = (a[7:0] == dst[7:0]); modelCf = (a[7:0] < dst[7:0]); end
      end
      if (op == 1) ac = w ? src : {ac[15:8], src[7:0]};
      if (usesSrc) sp = d ? sp - step : sp + step;
      if (usesDst) dp = d ? dp - step : dp + step;
      if (pfx != 0) cnt = cnt - 16'd1;
      if (pfx == 0) break;
      if (isCmp && ((pfx == 2 && !modelZf) || (pfx == 3 && modelZf))) break;
    end
    ncyc = nChk + nAcc + nFin + 1;
  endtask

  task automatic runCase(input int op, input int pfx, input bit w, input bit d,
                         input logic [15:0] sp, input logic [15:0] dp, input logic [15:0] cnt,
                         input logic [15:0] ac, input logic [15:0] ss, input logic [15:0] ds,
                         input string tag);
    logic [15:0] eSp, eDp, eCnt, eAcc;
    int eCyc, k;
    refMem = mem;
    model(op, pfx, w, d, sp, dp, cnt, ac, ss, ds, tag, eSp, eDp, eCnt, eAcc, eCyc);
    @(negedge clk);
    opCode = 3'(op); prefix = 2'(pfx); wide = w; dirDown = d;
    srcPtrIn = sp; dstPtrIn = dp; countIn = cnt; accIn = ac; srcSegIn = ss; dstSegIn = ds;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    check(k == eCyc, "R13", {tag, " done latency"}, k, eCyc);
    check(srcPtrOut == eSp, tag, "source pointer", srcPtrOut, eSp);
    check(dstPtrOut == eDp, tag, "destination pointer", dstPtrOut, eDp);
    check(countOut == eCnt, tag, "count", countOut, eCnt);
    check(accOut == eAcc, tag, "accumulator", accOut, eAcc);
    check(zeroFlag == modelZf, tag, "zero flag", {31'h0, zeroFlag}, {31'h0, modelZf});
    check(borrowFlag == modelCf, tag, "borrow flag", {31'h0, borrowFlag}, {31'h0, modelCf});
    check(expAddr.size() == 0, tag, "accesses left over", expAddr.size(), 0);
    expWe.delete(); expAddr.delete(); expData.delete(); expTag.delete();
    @(negedge clk);
    check(!done, "R13", "done lasts one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL R13 watchdog expired: actual running expected finished");
    finish();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[int'(phys(16'h1000, 16'h0100 + 16'(i)))] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) begin
      mem[int'(phys(16'h1000, 16'h0200 + 16'(i)))] = 8'h41 + 8'(i);
      mem[int'(phys(16'h2000, 16'h0600 + 16'(i)))] = (i < 3) ? 8'h41 + 8'(i) : 8'h58;
    end
    for (int i = 0; i < 8; i++) mem[int'(phys(16'h2000, 16'h0700 + 16'(i)))] = (i == 3) ? 8'h55 : 8'(i + 1);
    mem[int'(phys(16'h1000, 16'h0210))] = 8'h00; mem[int'(phys(16'h1000, 16'h0211))] = 8'h01;
    mem[int'(phys(16'h2000, 16'h0610))] = 8'h00; mem[int'(phys(16'h2000, 16'h0611))] = 8'h02;
    for (int i = 0; i < 8; i++) begin
      mem[int'(phys(16'h1000, 16'h0220 + 16'(i)))] = 8'h90 + 8'(i);
      mem[int'(phys(16'h2000, 16'h0620 + 16'(i)))] = 8'h90 + 8'(i);
    end

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !busy, "R1", "done/busy in reset", {30'h0, done, busy}, 32'h0);
    check(!memRead && !memWrite, "R1", "no access in reset", {30'h0, memRead, memWrite}, 32'h0);
    check(srcPtrOut == 0 && countOut == 0 && accOut == 0, "R1", "registers cleared",
          {srcPtrOut, countOut}, 32'h0);
    check(!zeroFlag && !borrowFlag, "R1", "flags cleared", {30'h0, zeroFlag, borrowFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", {30'h0, busy, done}, 32'h0);

    runCase(0, 1, 0, 0, 16'h0100, 16'h0300, 16'd5, 16'h0000, 16'h1000, 16'h2000, "R3");
    runCase(2, 1, 1, 0, 16'h0000, 16'h0400, 16'd5, 16'hBEEF, 16'h1000, 16'h2000, "R5");
    runCase(0, 1, 1, 1, 16'h0120, 16'h0500, 16'd3, 16'h0000, 16'h1000, 16'h2000, "R8");
    runCase(1, 0, 0, 0, 16'h0105, 16'h0000, 16'd7, 16'h1234, 16'h1000, 16'h2000, "R12");
    runCase(1, 0, 1, 1, 16'h0110, 16'h0000, 16'd2, 16'h0000, 16'h1000, 16'h2000, "R4");
    runCase(3, 2, 0, 0, 16'h0200, 16'h0600, 16'd6, 16'h0000, 16'h1000, 16'h2000, "R11");
    runCase(4, 3, 0, 0, 16'h0000, 16'h0700, 16'd8, 16'h0055, 16'h1000, 16'h2000, "R7");
    runCase(0, 1, 0, 0, 16'h0100, 16'h0300, 16'd0, 16'h0000, 16'h1000, 16'h2000, "R9");
    runCase(3, 0, 1, 0, 16'h0210, 16'h0610, 16'd9, 16'h0000, 16'h1000, 16'h2000, "R6");
    runCase(3, 2, 1, 0, 16'h0220, 16'h0620, 16'd4, 16'h0000, 16'h1000, 16'h2000, "R10");
    runCase(2, 0, 0, 0, 16'h0000, 16'h0020, 16'd1, 16'h00A5, 16'h1000, 16'hFFFF, "R2");
    runCase(0, 2, 0, 0, 16'h0108, 16'h0800, 16'd3, 16'h0000, 16'h1000, 16'h2000, "R10");
    runCase(2, 3, 0, 1, 16'h0000, 16'h0810, 16'd2, 16'h0077, 16'h1000, 16'h2000, "R10");
    runCase(4, 3, 1, 1, 16'h0000, 16'h0626, 16'd3, 16'h1111, 16'h1000, 16'h2000, "R11");
    finish();
  end
endmodule